// File: doc/BRIEF.md
# Non-Retriggerable One-Shot Pulse Generator

This block is a clocked stand-in for an edge-triggered monostable. Its timing network is a down-counter: a pulse lasts a number of clock cycles given on a duration input. The block has three control inputs: an active-low trigger, an active-high trigger and an active-low clear. Each one crosses into the clock domain through a two-flop synchronizer, and edges are then detected on the synchronized copies.

A pulse can start in three ways. The first is a rising edge on the high trigger while the low trigger is low. The second is a falling edge on the low trigger while the high trigger is high. The third is a rising edge on the clear while the low trigger is low and the high trigger is high. The first two also need the clear to be high. Once a pulse runs, the trigger inputs cannot stretch it or restart it. Clear can still cut it short.

Both the true output and its complement come from registers.

Top module: `oneshot_pulse`

## Requirements
- R1: While reset is asserted, and after it is released, the true output is 0 and the complement is 1. The input levels present when reset is released never start a pulse.
- R2: A rising edge on `trigHi`, seen while `trigLoN` is 0 and `clrN` is 1, starts a pulse.
- R3: A falling edge on `trigLoN`, seen while `trigHi` is 1 and `clrN` is 1, starts a pulse.
- R4: A rising edge on `clrN`, seen while `trigLoN` is 0 and `trigHi` is 1, starts a pulse.
- R5: A pulse stays high for exactly `durCycles` clock cycles, with a value of 0 treated as 1. The duration is taken when the trigger is recognised. How long the trigger input is held does not change the length.
- R6: The output rises on the third rising clock edge after a trigger input changes. That is two synchronizer stages plus the output register.
- R7: Trigger edges that arrive while a pulse is active are ignored, and the pulse is neither extended nor restarted. A trigger seen in the last cycle of a pulse is also ignored. A trigger seen one cycle later starts a new pulse with one low cycle between the two pulses.
- R8: When `clrN` goes to 0, the output falls three rising edges later. It stays 0 while `clrN` is 0, and any trigger edges during that time are ignored.
- R9: `pulseN` is the inverse of `pulse` in every cycle.
- R10: Edges without their arming condition start nothing. This covers a `trigHi` rise while `trigLoN` is 1, a `trigLoN` fall while `trigHi` is 0, and a `clrN` rise while `trigLoN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigLoN | input | 1 | Active-low trigger, acts on its falling edge |
| trigHi | input | 1 | Active-high trigger, acts on its rising edge |
| clrN | input | 1 | Active-low clear; its rising edge can also trigger |
| durCycles | input | CNT_W | Pulse length in clock cycles (0 behaves as 1) |
| pulse | output | 1 | True one-shot output |
| pulseN | output | 1 | Registered complement of `pulse` |

## Verification
The bench sweeps every duration from 0 to 20, plus the full-scale value, through all three trigger paths, and varies how long the trigger is held each time. This catches an off-by-one counter, a zero duration that wraps to a full-scale pulse, and a length that follows the trigger hold time. It places a new edge in the last cycle of a pulse and then one cycle later. A design that compares against the wrong counter state would merge the two pulses or lose the second one. Clear is pulled in the middle of a pulse while the triggers keep moving, and it is released with the arming condition unmet. A weak clear override would let the pulse resume or restart. Finally, reset is released with both triggers already at their armed levels, so a design whose edge detector compares against reset values would emit a spurious pulse.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;   // start a pulse, capture the duration
    logic clear;  // force the output low
  } ctrlStrobes_t;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int                WIDTH   = 3,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain[s] <= RST_VAL;
      end else if (s == 0) begin
        chain[s] <= asyncIn;
      end else begin
        chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         trigLoN,
  input  logic         trigHi,
  input  logic         clrN,
  input  logic         busy,
  output ctrlStrobes_t strb
);

  localparam int WARM_W   = $clog2(SYNC_STAGES + 2);
  localparam int WARM_END = SYNC_STAGES + 1;

  // bit 2 = trigLoN, bit 1 = trigHi, bit 0 = clrN; idle levels on reset
  localparam logic [2:0] IDLE_LEVELS = 3'b101;

  logic [2:0] rawVec;
  logic [2:0] syncVec;
  logic [2:0] prevVec;
  logic [WARM_W-1:0] warmCnt;
  logic primed;

  logic aLvl, bLvl, cLvl;
  logic aPrev, bPrev, cPrev;
  logic bRise, aFall, cRise;
  logic armedB, armedA, armedC;
  logic trigHit;

  assign rawVec = {trigLoN, trigHi, clrN};

  oneshot_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (IDLE_LEVELS)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawVec),
    .syncOut (syncVec)
  );

  // Previous synchronized levels for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevVec <= IDLE_LEVELS;
    end else begin
      prevVec <= syncVec;
    end
  end

  // Hold off edge detection until reset values have left the pipeline
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt <= '0;
    end else if (!primed) begin
      warmCnt <= warmCnt + 1'b1;
    end
  end

  assign primed = (warmCnt == WARM_W'(WARM_END));

  assign aLvl  = syncVec[2];
  assign bLvl  = syncVec[1];
  assign cLvl  = syncVec[0];
  assign aPrev = prevVec[2];
  assign bPrev = prevVec[1];
  assign cPrev = prevVec[0];

  assign bRise = bLvl & ~bPrev;
  assign aFall = ~aLvl & aPrev;
  assign cRise = cLvl & ~cPrev;

  assign armedB = bRise & ~aLvl & cLvl;
  assign armedA = aFall & bLvl & cLvl;
  assign armedC = cRise & ~aLvl & bLvl;

  assign trigHit = primed & (armedB | armedA | armedC);

  always_comb begin
    strb       = '0;
    strb.clear = ~cLvl;
    strb.load  = trigHit & ~busy & cLvl;
  end

endmodule

// File: rtl/oneshot_datapath.sv
module oneshot_datapath
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [CNT_W-1:0] durCycles,
  output logic             busy,
  output logic             pulse,
  output logic             pulseN
);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] loadVal;
  logic             lastCycle;

  // Cycles left after the first; zero duration acts as one
  assign loadVal   = (durCycles == '0) ? '0 : durCycles - 1'b1;
  assign lastCycle = pulse & (remain == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulse  <= 1'b0;
      pulseN <= 1'b1;
      remain <= '0;
    end else if (strb.clear) begin
      pulse  <= 1'b0;
      pulseN <= 1'b1;
      remain <= '0;
    end else if (strb.load) begin
      pulse  <= 1'b1;
      pulseN <= 1'b0;
      remain <= loadVal;
    end else if (lastCycle) begin
      pulse  <= 1'b0;
      pulseN <= 1'b1;
    end else if (pulse) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy = pulse;

endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
  import oneshot_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigLoN,
  input  logic             trigHi,
  input  logic             clrN,
  input  logic [CNT_W-1:0] durCycles,
  output logic             pulse,
  output logic             pulseN
);

  ctrlStrobes_t strb;
  logic         busy;

  oneshot_ctrl #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .trigLoN (trigLoN),
    .trigHi  (trigHi),
    .clrN    (clrN),
    .busy    (busy),
    .strb    (strb)
  );

  oneshot_datapath #(
    .CNT_W (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .durCycles (durCycles),
    .busy      (busy),
    .pulse     (pulse),
    .pulseN    (pulseN)
  );

endmodule

// File: rtl/oneshot_checker.sv
module oneshot_checker
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input ctrlStrobes_t     strb,
  input logic [CNT_W-1:0] durCycles,
  input logic             pulse,
  input logic             pulseN
);

  logic [CNT_W:0] capLen;
  logic [CNT_W:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capLen <= '0;
      runLen <= '0;
    end else begin
      if (strb.load && !pulse) begin
        capLen <= (durCycles == '0) ? (CNT_W+1)'(1) : {1'b0, durCycles};
      end
      runLen <= pulse ? runLen + 1'b1 : '0;
    end
  end

  // R9: complement register always opposite the true output
  p_qn_inverse_r9: assert property (@(posedge clk) disable iff (!rstN)
    pulseN == ~pulse);

  // R8: a synchronized clear drops the output on the next edge
  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !pulse);

  // R6: the output only rises after a load strobe
  p_rise_needs_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulse) |-> $past(strb.load));

  // R5: a running pulse never exceeds its captured length
  p_len_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    pulse |-> (runLen < capLen));

  // R5: a pulse that ends without clear ran exactly its captured length
  p_len_exact_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pulse) && !$past(strb.clear)) |-> (runLen == capLen));

  // R7: short of its length and without clear, a pulse keeps going
  p_no_cut_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pulse && !strb.clear && (runLen + 1'b1 < capLen)) |=> pulse);

endmodule

bind oneshot_pulse oneshot_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .strb      (strb),
  .durCycles (durCycles),
  .pulse     (pulse),
  .pulseN    (pulseN)
);

// File: tb/test_oneshot_pulse.sv
module test_oneshot_pulse;

  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN;
  logic trigLoN, trigHi, clrN;
  logic [CNT_W-1:0] durCycles;
  logic pulse, pulseN;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  oneshot_pulse #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_oneshot_pulse (
    .clk       (clk),
    .rstN      (rstN),
    .trigLoN   (trigLoN),
    .trigHi    (trigHi),
    .clrN      (clrN),
    .durCycles (durCycles),
    .pulse     (pulse),
    .pulseN    (pulseN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic goIdle();
    trigLoN = 1'b1;
    trigHi  = 1'b0;
    clrN    = 1'b1;
  endtask

  task automatic idleWait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // kind 0: trigHi path, 1: trigLoN path, 2: clrN path
  task automatic runPulse(input int kind, input int n, input int hold, input string req);
    int firstRise = -1;
    int highCnt = 0;
    int qnBad = 0;
    int preHigh = 0;
    int expLen = (n == 0) ? 1 : n;
    int steps = expLen + 8;
    durCycles = CNT_W'(n);
    if (kind == 0) begin
      trigLoN = 1'b0;
    end else if (kind == 1) begin
      trigHi = 1'b1;
    end else begin
      clrN = 1'b0;
      for (int i = 0; i < 4; i++) begin @(negedge clk); preHigh += int'(pulse); end
      trigLoN = 1'b0;
      trigHi  = 1'b1;
    end
    for (int i = 0; i < 4; i++) begin @(negedge clk); preHigh += int'(pulse); end
    if (kind == 0) trigHi = 1'b1;
    else if (kind == 1) trigLoN = 1'b0;
    else clrN = 1'b1;
    for (int s = 1; s <= steps; s++) begin
      @(negedge clk);
      if (pulse && firstRise < 0) firstRise = s;
      highCnt += int'(pulse);
      qnBad += int'(pulseN == pulse);
      if (s == hold) goIdle();
    end
    goIdle();
    chk(preHigh == 0, "R10 arming phase quiet", preHigh, 0);
    chk(firstRise == 3, "R6 rise latency", firstRise, 3);
    chk(highCnt == expLen, req, highCnt, expLen);
    chk(qnBad == 0, "R9 complement", qnBad, 0);
    idleWait(6);
  endtask

  initial begin
    automatic logic qArr [0:40];
    int cnt;
    rstN = 1'b0;
    trigLoN = 1'b0;
    trigHi = 1'b1;
    clrN = 1'b1;
    durCycles = 8'd5;
    idleWait(3);
    chk(pulse == 1'b0 && pulseN == 1'b1, "R1 in reset", {pulse, pulseN}, 1);
    rstN = 1'b1;
    cnt = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); cnt += int'(pulse) + int'(!pulseN); end
    chk(cnt == 0, "R1 no pulse after release with armed levels", cnt, 0);
    goIdle();
    idleWait(6);

    // Duration sweep over all three paths with varying hold time (R2 R3 R4 R5)
    for (int n = 0; n <= 20; n++) begin
      for (int k = 0; k < 3; k++) begin
        runPulse(k, n, 1 + (n * 3 + k) % 7,
                 (k == 0) ? "R2 R5 length" : (k == 1) ? "R3 R5 length" : "R4 R5 length");
      end
    end
    runPulse(0, 255, 1, "R5 full scale short hold");
    runPulse(1, 12, 40, "R5 long hold");

    // R7: edge in last cycle ignored; edge mid-pulse ignored
    durCycles = 8'd10;
    trigLoN = 1'b0;
    idleWait(4);
    trigHi = 1'b1;
    for (int s = 1; s <= 20; s++) begin
      @(negedge clk);
      qArr[s] = pulse;
      if (s == 2) trigHi = 1'b0;
      if (s == 5) trigHi = 1'b1;
      if (s == 7) trigHi = 1'b0;
      if (s == 10) trigHi = 1'b1;
    end
    cnt = 0;
    for (int s = 1; s <= 20; s++) cnt += int'(qArr[s]);
    chk(cnt == 10, "R7 no extend or restart", cnt, 10);
    chk(qArr[12] == 1'b1 && qArr[13] == 1'b0, "R7 ends on time", int'(qArr[13]), 0);
    goIdle();
    idleWait(8);

    // R7: edge one cycle after the last high cycle starts a new pulse
    trigLoN = 1'b0;
    idleWait(4);
    trigHi = 1'b1;
    for (int s = 1; s <= 30; s++) begin
      @(negedge clk);
      qArr[s] = pulse;
      if (s == 7) trigHi = 1'b0;
      if (s == 11) trigHi = 1'b1;
    end
    chk(qArr[13] == 1'b0, "R7 single low gap", int'(qArr[13]), 0);
    chk(qArr[14] == 1'b1, "R7 next pulse starts", int'(qArr[14]), 1);
    cnt = 0;
    for (int s = 1; s <= 30; s++) cnt += int'(qArr[s]);
    chk(cnt == 20, "R7 two full pulses", cnt, 20);
    goIdle();
    idleWait(8);

    // R8: clear mid-pulse, triggers toggling under clear, release unarmed
    durCycles = 8'd20;
    trigLoN = 1'b0;
    idleWait(4);
    trigHi = 1'b1;
    for (int s = 1; s <= 36; s++) begin
      @(negedge clk);
      if (s <= 40) qArr[s > 40 ? 40 : s] = pulse;
      if (s == 5) clrN = 1'b0;
      if (s == 10) trigHi = 1'b0;
      if (s == 12) trigHi = 1'b1;
      if (s == 20) begin trigLoN = 1'b1; trigHi = 1'b0; end
      if (s == 22) clrN = 1'b1;
    end
    chk(qArr[7] == 1'b1, "R8 high before clear lands", int'(qArr[7]), 1);
    chk(qArr[8] == 1'b0, "R8 clear drops output", int'(qArr[8]), 0);
    cnt = 0;
    for (int s = 8; s <= 36; s++) cnt += int'(qArr[s]);
    chk(cnt == 0, "R8 held low and no restart", cnt, 0);
    goIdle();
    idleWait(6);

    // R10: unarmed edges
    durCycles = 8'd4;
    trigHi = 1'b1;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); cnt += int'(pulse); end
    chk(cnt == 0, "R10 trigHi rise with trigLoN high", cnt, 0);
    trigHi = 1'b0;
    idleWait(4);
    trigLoN = 1'b0;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); cnt += int'(pulse); end
    chk(cnt == 0, "R10 trigLoN fall with trigHi low", cnt, 0);
    trigLoN = 1'b1;
    clrN = 1'b0;
    idleWait(5);
    trigHi = 1'b1;
    idleWait(5);
    clrN = 1'b1;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); cnt += int'(pulse); end
    chk(cnt == 0, "R10 clrN rise with trigLoN high", cnt, 0);
    goIdle();
    idleWait(4);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChk++;
      nFail++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule